// File: doc/BRIEF.md
# NAND Operation Sequencer With Completion Interrupt

This block is the control core of a small NAND flash controller seen by software as a 16-bit register window. Software loads a command byte or an address byte, then launches exactly one flash operation by writing a one-hot start bit. The block generates the command-latch, address-latch, write-strobe, read-strobe and chip-enable pin activity for that one operation. It then waits on the flash ready/busy line, so software never watches that pin. When the flash reports ready, the block raises a sticky done flag. An interrupt follows from that flag unless a mask bit blocks it.

Every flash cycle is its own host-triggered operation. A command cycle and an address cycle each produce one write strobe. Page program and page read produce a fixed burst of strobes that stands in for a full data transfer. Read ID and read status produce read strobes, and the byte seen on the last strobe is kept for software to read. A self-clearing soft reset aborts any operation in progress.

The sequencer is a five-state machine. ST_IDLE moves to ST_STRB_LO on an accepted start. ST_STRB_LO moves to ST_STRB_HI after the low phase. ST_STRB_HI moves back to ST_STRB_LO while beats remain, and to ST_SETTLE after the last beat. ST_SETTLE moves to ST_WAIT_RDY after the settle time. ST_WAIT_RDY moves to ST_IDLE and reports completion once ready/busy reads high. From any state, a soft reset sends the machine to ST_IDLE.

Top module: `nfc_op_core`

Register word addresses:

| Address | Contents |
|---------|----------|
| 0 | command register (16 bits stored, low byte used) |
| 1 | address register (16 bits stored, low byte used) |
| 2 | operation control: start bits and done flag |
| 3 | configuration |
| 4 | bank: chip select in bits 6:5 |
| 5 | captured read byte (read-only) |

## Requirements
- R1: After reset, all readable registers return 0. Write and read strobes are high, both latch pins are low, all chip-enable outputs are high, and irq is low.
- R2: Chip enable is active low. Output ce_n[k] is low only when configuration bit 7 is 1 and bank bits 6:5 equal k. Otherwise every output is high.
- R3: Start bit 0 of register 2 runs a command cycle. The low byte of register 0 is driven on dq with dq_oe high, and CLE is high for the whole strobe. WE is low for 2 clocks, then high for 2 clocks.
- R4: Start bit 1 runs an address cycle. It has the same timing as R3 but uses the low byte of register 1, with ALE high instead of CLE.
- R5: Start bit 2 runs a page program. It produces PAGE_BEATS write strobes of 2 low and 2 high clocks each. dq carries the beat index 0, 1, 2 and so on, with both latches low.
- R6: Start bits 3, 4 and 5 (page read, read ID, read status) produce PAGE_BEATS, ID_BEATS and 1 read strobes respectively, each 2 low and 2 high clocks, with WE held high. The dq_in byte at the end of each low phase is stored in register 5.
- R7: After the last strobe, 2 settle clocks follow. The block then waits for rb_n high, and the done flag (bit 15 of register 2) sets on the edge where rb_n is seen high. While busy, bit k of register 2 reads 1 for the running operation. Once done, all start bits read 0.
- R8: The done flag is cleared only by a write to register 2 with bit 15 equal to 0. A write with bit 15 equal to 1 leaves it unchanged.
- R9: irq is high exactly when the done flag is 1 and the mask bit (configuration bit 4) is 0.
- R10: When several start bits are written at once, the lowest-numbered one runs. A start write that arrives while an operation is busy, or during soft reset, has no effect.
- R11: Writing configuration bit 6 starts a soft reset. It aborts any operation, returns the pins to idle, and clears the done flag and start bits. Bit 6 reads 1 for RST_CYCLES clocks and then clears itself. The command, address and bank registers and configuration bits 4 and 7 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register word address |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data (combinational) |
| nf_dq_out | output | 8 | flash bus output byte |
| nf_dq_oe | output | 1 | flash bus output enable |
| nf_dq_in | input | 8 | flash bus input byte |
| nf_cle | output | 1 | command latch enable |
| nf_ale | output | 1 | address latch enable |
| nf_we_n | output | 1 | write strobe, active low |
| nf_re_n | output | 1 | read strobe, active low |
| nf_ce_n | output | CE_COUNT | chip enables, active low |
| nf_rb_n | input | 1 | ready (1) / busy (0) |
| irq | output | 1 | completion interrupt |

## Verification
The bench follows every operation cycle by cycle and checks strobe width, latch level and bus byte. A sequencer with an off-by-one phase counter or beat counter would show a stretched or missing strobe. It holds the flash busy to show that completion waits for ready, and that a start write arriving meanwhile neither adds strobes nor changes the active bit; a design that completes early or accepts a second start fails there. Combined start bits check the lowest-wins priority. A soft reset in the middle of an operation shows the abort, the self-clear timing and the registers that are kept. A reset that wiped configuration or never cleared itself would be caught.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int OP_BITS  = 6;
    localparam int DONE_BIT = 15;
    localparam int MASK_BIT = 4;
    localparam int SRST_BIT = 6;
    localparam int CEEN_BIT = 7;
    localparam int SEL_LSB  = 5;

    localparam int REG_CMD   = 0;
    localparam int REG_ADDR  = 1;
    localparam int REG_OPCTL = 2;
    localparam int REG_CFG   = 3;
    localparam int REG_BANK  = 4;
    localparam int REG_RX    = 5;

    // value equals the start-bit position in the control register
    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_PROG = 3'd2,
        OP_READ = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } nfc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRB_LO,
        ST_STRB_HI,
        ST_SETTLE,
        ST_WAIT_RDY
    } seq_state_e;
endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
    import nfc_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CE_COUNT   = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [15:0]                 wdata,
    output logic [15:0]                 rdata,
    input  logic                        seq_busy,
    input  logic                        seq_fin,
    input  logic                        cap_en,
    input  logic [7:0]                  cap_byte,
    output logic                        start_req,
    output nfc_op_e                     start_op,
    output logic [7:0]                  cmd_byte,
    output logic [7:0]                  addr_byte,
    output logic                        cfg_mask,
    output logic                        cfg_ceen,
    output logic [$clog2(CE_COUNT)-1:0] bank_sel,
    output logic                        srst_active,
    output logic                        done_flag
);
    localparam int SEL_W = $clog2(CE_COUNT);
    localparam int RST_W = $clog2(RST_CYCLES + 1);

    logic [15:0]        cmd_q, addr_q;
    logic [OP_BITS-1:0] opbits_q;
    logic               done_q, mask_q, ceen_q, srst_q;
    logic [SEL_W-1:0]   sel_q;
    logic [7:0]         rx_q;
    logic [RST_W-1:0]   rcnt_q;
    logic               wr_cmd, wr_addr, wr_op, wr_cfg, wr_bank;
    logic [2:0]         pick;

    always_comb begin
        wr_cmd  = wr_en && (addr == ADDR_W'(REG_CMD));
        wr_addr = wr_en && (addr == ADDR_W'(REG_ADDR));
        wr_op   = wr_en && (addr == ADDR_W'(REG_OPCTL));
        wr_cfg  = wr_en && (addr == ADDR_W'(REG_CFG));
        wr_bank = wr_en && (addr == ADDR_W'(REG_BANK));
    end

    // lowest set start bit wins: scan downward so the last hit is the lowest
    always_comb begin
        pick = '0;
        for (int i = OP_BITS - 1; i >= 0; i--) begin
            if (wdata[i]) pick = 3'(i);
        end
    end

    assign start_req = wr_op && (|wdata[OP_BITS-1:0]) && !seq_busy && !srst_q;
    assign start_op  = nfc_op_e'(pick);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            addr_q   <= '0;
            opbits_q <= '0;
            done_q   <= 1'b0;
            mask_q   <= 1'b0;
            ceen_q   <= 1'b0;
            srst_q   <= 1'b0;
            sel_q    <= '0;
            rx_q     <= '0;
            rcnt_q   <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_addr) addr_q <= wdata;
            if (wr_bank) sel_q  <= wdata[SEL_LSB +: SEL_W];
            if (wr_cfg) begin
                mask_q <= wdata[MASK_BIT];
                ceen_q <= wdata[CEEN_BIT];
            end
            if (cap_en) rx_q <= cap_byte;

            if (srst_q) begin
                if (rcnt_q == RST_W'(RST_CYCLES - 1)) srst_q <= 1'b0;
                else                                  rcnt_q <= rcnt_q + 1'b1;
            end else if (wr_cfg && wdata[SRST_BIT]) begin
                srst_q <= 1'b1;
                rcnt_q <= '0;
            end

            if (srst_q)         opbits_q <= '0;
            else if (start_req) opbits_q <= OP_BITS'(1) << pick;
            else if (seq_fin)   opbits_q <= '0;

            if (srst_q)                         done_q <= 1'b0;
            else if (seq_fin)                   done_q <= 1'b1;
            else if (wr_op && !wdata[DONE_BIT]) done_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_CMD):   rdata = cmd_q;
            ADDR_W'(REG_ADDR):  rdata = addr_q;
            ADDR_W'(REG_OPCTL): rdata = {done_q, {(15 - OP_BITS){1'b0}}, opbits_q};
            ADDR_W'(REG_CFG): begin
                rdata[MASK_BIT] = mask_q;
                rdata[SRST_BIT] = srst_q;
                rdata[CEEN_BIT] = ceen_q;
            end
            ADDR_W'(REG_BANK):  rdata[SEL_LSB +: SEL_W] = sel_q;
            ADDR_W'(REG_RX):    rdata = {8'h00, rx_q};
            default:            rdata = '0;
        endcase
    end

    assign cmd_byte    = cmd_q[7:0];
    assign addr_byte   = addr_q[7:0];
    assign cfg_mask    = mask_q;
    assign cfg_ceen    = ceen_q;
    assign bank_sel    = sel_q;
    assign srst_active = srst_q;
    assign done_flag   = done_q;
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int STROBE_LO  = 2,
    parameter int STROBE_HI  = 2,
    parameter int SETTLE_CYC = 2,
    parameter int PAGE_BEATS = 4,
    parameter int ID_BEATS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       start_req,
    input  nfc_op_e    start_op,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] addr_byte,
    input  logic       rb_n,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       busy,
    output logic       fin,
    output logic       cap_en
);
    localparam int MAX_BEATS = (PAGE_BEATS > ID_BEATS) ? PAGE_BEATS : ID_BEATS;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
    localparam int PH_A      = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int MAX_PH    = (PH_A > SETTLE_CYC) ? PH_A : SETTLE_CYC;
    localparam int PH_W      = $clog2(MAX_PH + 1);

    seq_state_e        state_q;
    nfc_op_e           op_q;
    logic [BEAT_W-1:0] beat_q;
    logic [PH_W-1:0]   ph_q;
    logic              is_wr;

    function automatic logic [BEAT_W-1:0] last_beat(input nfc_op_e op);
        case (op)
            OP_PROG, OP_READ: return BEAT_W'(PAGE_BEATS - 1);
            OP_ID:            return BEAT_W'(ID_BEATS - 1);
            default:          return '0;
        endcase
    endfunction

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CMD;
            beat_q  <= '0;
            ph_q    <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            ph_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        op_q    <= start_op;
                        beat_q  <= '0;
                        ph_q    <= '0;
                        state_q <= ST_STRB_LO;
                    end
                end
                ST_STRB_LO: begin
                    if (ph_q == PH_W'(STROBE_LO - 1)) begin
                        ph_q    <= '0;
                        state_q <= ST_STRB_HI;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_STRB_HI: begin
                    if (ph_q == PH_W'(STROBE_HI - 1)) begin
                        ph_q <= '0;
                        if (beat_q == last_beat(op_q)) begin
                            state_q <= ST_SETTLE;
                        end else begin
                            beat_q  <= beat_q + 1'b1;
                            state_q <= ST_STRB_LO;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (ph_q == PH_W'(SETTLE_CYC - 1)) begin
                        ph_q    <= '0;
                        state_q <= ST_WAIT_RDY;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_WAIT_RDY: begin
                    if (rb_n) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // pin and status outputs
    always_comb begin
        logic strobing;
        is_wr    = (op_q == OP_CMD) || (op_q == OP_ADDR) || (op_q == OP_PROG);
        strobing = (state_q == ST_STRB_LO) || (state_q == ST_STRB_HI);
        cle      = strobing && (op_q == OP_CMD);
        ale      = strobing && (op_q == OP_ADDR);
        we_n     = !((state_q == ST_STRB_LO) && is_wr);
        re_n     = !((state_q == ST_STRB_LO) && !is_wr);
        dq_oe    = strobing && is_wr;
        dq_out   = '0;
        if (dq_oe) begin
            case (op_q)
                OP_CMD:  dq_out = cmd_byte;
                OP_ADDR: dq_out = addr_byte;
                default: dq_out = 8'(beat_q);
            endcase
        end
        busy   = (state_q != ST_IDLE);
        fin    = (state_q == ST_WAIT_RDY) && rb_n && !abort;
        cap_en = (state_q == ST_STRB_LO) && !is_wr && (ph_q == PH_W'(STROBE_LO - 1));
    end
endmodule

// File: rtl/nfc_ce_decode.sv
module nfc_ce_decode #(
    parameter int CE_COUNT = 4
) (
    input  logic                        ce_en,
    input  logic [$clog2(CE_COUNT)-1:0] sel,
    output logic [CE_COUNT-1:0]         ce_n
);
    localparam int SEL_W = $clog2(CE_COUNT);

    for (genvar k = 0; k < CE_COUNT; k++) begin : g_ce
        assign ce_n[k] = !(ce_en && (sel == SEL_W'(k)));
    end
endmodule

// File: rtl/nfc_op_core.sv
module nfc_op_core
    import nfc_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CE_COUNT   = 4,
    parameter int STROBE_LO  = 2,
    parameter int STROBE_HI  = 2,
    parameter int SETTLE_CYC = 2,
    parameter int PAGE_BEATS = 4,
    parameter int ID_BEATS   = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic [7:0]          nf_dq_out,
    output logic                nf_dq_oe,
    input  logic [7:0]          nf_dq_in,
    output logic                nf_cle,
    output logic                nf_ale,
    output logic                nf_we_n,
    output logic                nf_re_n,
    output logic [CE_COUNT-1:0] nf_ce_n,
    input  logic                nf_rb_n,
    output logic                irq
);
    localparam int SEL_W = $clog2(CE_COUNT);

    logic             start_req, seq_busy, seq_fin, cap_en;
    nfc_op_e          start_op;
    logic [7:0]       cmd_byte, addr_byte;
    logic             cfg_mask, cfg_ceen, srst_active, done_flag;
    logic [SEL_W-1:0] bank_sel;

    nfc_regs #(
        .ADDR_W(ADDR_W), .CE_COUNT(CE_COUNT), .RST_CYCLES(RST_CYCLES)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .seq_busy(seq_busy),
        .seq_fin(seq_fin), .cap_en(cap_en), .cap_byte(nf_dq_in),
        .start_req(start_req), .start_op(start_op), .cmd_byte(cmd_byte),
        .addr_byte(addr_byte), .cfg_mask(cfg_mask), .cfg_ceen(cfg_ceen),
        .bank_sel(bank_sel), .srst_active(srst_active), .done_flag(done_flag)
    );

    nfc_seq #(
        .STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI), .SETTLE_CYC(SETTLE_CYC),
        .PAGE_BEATS(PAGE_BEATS), .ID_BEATS(ID_BEATS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .abort(srst_active), .start_req(start_req),
        .start_op(start_op), .cmd_byte(cmd_byte), .addr_byte(addr_byte),
        .rb_n(nf_rb_n), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
        .re_n(nf_re_n), .dq_out(nf_dq_out), .dq_oe(nf_dq_oe),
        .busy(seq_busy), .fin(seq_fin), .cap_en(cap_en)
    );

    nfc_ce_decode #(.CE_COUNT(CE_COUNT)) ce_i (
        .ce_en(cfg_ceen), .sel(bank_sel), .ce_n(nf_ce_n)
    );

    assign irq = done_flag && !cfg_mask;
endmodule

// File: rtl/nfc_op_core_chk.sv
module nfc_op_core_chk #(
    parameter int CE_COUNT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cle,
    input logic                ale,
    input logic                we_n,
    input logic                re_n,
    input logic                dq_oe,
    input logic [CE_COUNT-1:0] ce_n,
    input logic                rb_n,
    input logic                done_flag,
    input logic                srst_active
);
    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n) && !(dq_oe && !re_n));

    // R3
    we_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n);

    // R3
    we_max_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n)) |=> we_n);

    // R7
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(rb_n));

    // R11
    srst_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_active) |-> (we_n && re_n && !cle && !ale));
endmodule

bind nfc_op_core nfc_op_core_chk #(.CE_COUNT(CE_COUNT)) chk_i (
    .clk(clk), .rst_n(rst_n), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
    .re_n(nf_re_n), .dq_oe(nf_dq_oe), .ce_n(nf_ce_n), .rb_n(nf_rb_n),
    .done_flag(done_flag), .srst_active(srst_active)
);

// File: tb/nfc_op_core_tb_top.sv
module nfc_op_core_tb_top;
    localparam int PAGE_BEATS = 4;
    localparam int ID_BEATS   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  nf_dq_out, nf_dq_in;
    logic        nf_dq_oe, nf_cle, nf_ale, nf_we_n, nf_re_n, irq;
    logic [3:0]  nf_ce_n;
    logic        nf_rb_n = 1'b1;
    logic [7:0]  rx_base = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int we_lo = 0;
    int re_falls = 0;
    logic re_prev = 1'b1;

    always #2 clk = ~clk;

    nfc_op_core #(.PAGE_BEATS(PAGE_BEATS), .ID_BEATS(ID_BEATS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_rb_n(nf_rb_n), .irq(irq)
    );

    // flash-side model: each read strobe presents the next byte
    assign nf_dq_in = rx_base + 8'(re_falls);

    always @(negedge clk) begin
        if (rst_n) begin
            if (!nf_we_n) we_lo = we_lo + 1;
            if (!nf_re_n && re_prev) re_falls = re_falls + 1;
            re_prev = nf_re_n;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pins_idle(input string req);
        check(req, "we_n idle", nf_we_n, 1);
        check(req, "re_n idle", nf_re_n, 1);
        check(req, "cle idle", nf_cle, 0);
        check(req, "ale idle", nf_ale, 0);
    endtask

    // runs one operation with ready high and checks every cycle
    task automatic run_op(input logic [15:0] start_val, input logic [5:0] onehot,
                          input int nbeats, input bit is_wr, input bit cle_e,
                          input bit ale_e, input bit beat_data,
                          input logic [7:0] dbyte, input string req);
        logic [15:0] v;
        int b;
        bit lo;
        wr(3'd2, start_val);
        rd(3'd2, v);
        check("R7", "start bit while busy", v, {10'd0, onehot});
        for (int idx = 0; idx < 4 * nbeats + 4; idx++) begin
            if (idx > 0) begin
                @(negedge clk);
                #1;
            end
            if (idx < 4 * nbeats) begin
                b  = idx / 4;
                lo = (idx % 4) < 2;
                check(req, "we_n", nf_we_n, !(lo && is_wr));
                check(req, "re_n", nf_re_n, !(lo && !is_wr));
                if (is_wr) begin
                    check(req, "cle", nf_cle, cle_e);
                    check(req, "ale", nf_ale, ale_e);
                    check(req, "dq_oe", nf_dq_oe, 1);
                    check(req, "dq", nf_dq_out, beat_data ? 8'(b) : dbyte);
                end
            end else begin
                pins_idle(req);
                if (idx == 4 * nbeats + 2) check("R7", "irq before done", irq, 0);
                if (idx == 4 * nbeats + 3) begin
                    check("R7", "irq at done", irq, 1);
                    rd(3'd2, v);
                    check("R7", "ctrl after done", v, 16'h8000);
                end
            end
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1", "register after reset", v, 0);
        end
        pins_idle("R1");
        check("R1", "ce_n after reset", nf_ce_n, 4'hF);
        check("R1", "irq after reset", irq, 0);

        // R2 chip-enable sweep
        for (int en = 0; en < 2; en++) begin
            for (int s = 0; s < 4; s++) begin
                wr(3'd4, 16'(s << 5));
                wr(3'd3, 16'(en << 7));
                #1;
                check("R2", "ce_n", nf_ce_n, en != 0 ? 4'(~(4'b1 << s)) : 4'hF);
                rd(3'd4, v);
                check("R2", "bank readback", v, 16'(s << 5));
            end
        end
        wr(3'd3, 16'h0000);

        // R3 command sweep, upper byte ignored
        for (int i = 0; i < 16; i++) begin
            wr(3'd0, 16'hA500 | 16'((i * 37 + 3) & 8'hFF));
            run_op(16'h0001, 6'b000001, 1, 1, 1, 0, 0, 8'((i * 37 + 3) & 8'hFF), "R3");
        end

        // R4 address sweep
        for (int i = 0; i < 16; i++) begin
            wr(3'd1, 16'h5A00 | 16'((i * 53 + 11) & 8'hFF));
            run_op(16'h0002, 6'b000010, 1, 1, 0, 1, 0, 8'((i * 53 + 11) & 8'hFF), "R4");
        end

        // R5 page program
        run_op(16'h0004, 6'b000100, PAGE_BEATS, 1, 0, 0, 1, 8'h00, "R5");
        check("R5", "write strobe cycles", we_lo, 2 * (32 + PAGE_BEATS));

        // R6 page read, read ID, read status
        rx_base = 8'h40;
        base = we_lo;
        run_op(16'h0008, 6'b001000, PAGE_BEATS, 0, 0, 0, 0, 8'h00, "R6");
        check("R6", "no write strobes on read", we_lo - base, 0);
        rd(3'd5, v);
        check("R6", "page read capture", v, {8'h00, rx_base + 8'(re_falls)});
        rx_base = 8'h98;
        run_op(16'h0010, 6'b010000, ID_BEATS, 0, 0, 0, 0, 8'h00, "R6");
        rd(3'd5, v);
        check("R6", "id capture", v, {8'h00, rx_base + 8'(re_falls)});
        check("R6", "read strobe count", re_falls, PAGE_BEATS + ID_BEATS);
        rx_base = 8'hC0;
        run_op(16'h0020, 6'b100000, 1, 0, 0, 0, 0, 8'h00, "R6");
        rd(3'd5, v);
        check("R6", "status capture", v, {8'h00, rx_base + 8'(re_falls)});

        // R9 mask, R8 sticky clear
        wr(3'd3, 16'h0010);
        #1;
        check("R9", "irq masked", irq, 0);
        rd(3'd2, v);
        check("R9", "done kept under mask", v, 16'h8000);
        wr(3'd3, 16'h0000);
        #1;
        check("R9", "irq unmasked", irq, 1);
        wr(3'd2, 16'h8000);
        rd(3'd2, v);
        check("R8", "write one keeps done", v, 16'h8000);
        wr(3'd2, 16'h0000);
        rd(3'd2, v);
        check("R8", "write zero clears done", v, 16'h0000);
        check("R8", "irq after clear", irq, 0);

        // R10 priority
        wr(3'd0, 16'h0070);
        wr(3'd1, 16'h0033);
        run_op(16'h003F, 6'b000001, 1, 1, 1, 0, 0, 8'h70, "R10");
        run_op(16'h0006, 6'b000010, 1, 1, 0, 1, 0, 8'h33, "R10");
        run_op(16'h0030, 6'b010000, ID_BEATS, 0, 0, 0, 0, 8'h00, "R10");

        // R7 and R10: wait on busy, ignore start while busy
        nf_rb_n = 1'b0;
        base = we_lo;
        wr(3'd2, 16'h0004);
        repeat (4 * PAGE_BEATS + 5) @(negedge clk);
        #1;
        check("R7", "irq while flash busy", irq, 0);
        rd(3'd2, v);
        check("R7", "active bit while busy", v, 16'h0004);
        wr(3'd2, 16'h0001);
        repeat (5) @(negedge clk);
        check("R10", "no strobes from ignored start", we_lo - base, 2 * PAGE_BEATS);
        rd(3'd2, v);
        check("R10", "ctrl after ignored start", v, 16'h0004);
        @(negedge clk);
        nf_rb_n = 1'b1;
        @(negedge clk);
        #1;
        rd(3'd2, v);
        check("R7", "done after ready", v, 16'h8000);
        check("R7", "irq after ready", irq, 1);

        // R11 soft reset aborts a stuck operation
        wr(3'd0, 16'h3C70);
        wr(3'd4, 16'h0040);
        nf_rb_n = 1'b0;
        wr(3'd2, 16'h0001);
        repeat (8) @(negedge clk);
        wr(3'd3, 16'h00D0);
        rd(3'd3, v);
        check("R11", "reset bit set", v, 16'h00D0);
        @(negedge clk);
        #1;
        rd(3'd2, v);
        check("R11", "ctrl cleared", v, 16'h0000);
        pins_idle("R11");
        check("R11", "irq cleared", irq, 0);
        repeat (6) @(negedge clk);
        rd(3'd3, v);
        check("R11", "reset bit self-clears, fields kept", v, 16'h0090);
        rd(3'd0, v);
        check("R11", "command kept", v, 16'h3C70);
        rd(3'd4, v);
        check("R11", "bank kept", v, 16'h0040);
        nf_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd2, v);
        check("R11", "no completion after abort", v, 16'h0000);

        // R10 start during soft reset ignored
        wr(3'd3, 16'h0040);
        base = we_lo;
        wr(3'd2, 16'h0001);
        repeat (8) @(negedge clk);
        check("R10", "no strobes during reset", we_lo - base, 0);
        rd(3'd2, v);
        check("R10", "ctrl after start in reset", v, 16'h0000);

        // R11 recovery
        run_op(16'h0001, 6'b000001, 1, 1, 1, 0, 0, 8'h70, "R11");

        report();
        $finish;
    end
endmodule